// File: doc/BRIEF.md
# Shared Multiply Engine with Per-Client Result Registers

This block lets several client cores share one fixed-latency arithmetic engine. A multiply pipeline stands in for the real iterative solver. An issue slot steps through the clients one per cycle. When a client has a request pending in its own slot, the operands enter the pipeline. A fixed number of cycles later, the 64-bit result is written into that client's result register as two 32-bit words, X and Y.

There is no queue. Each client owns one X/Y register and one valid bit, and a new result replaces whatever the register held. A client reads a word in one of two ways:

- A blocking read waits only while the client has work in flight and nothing valid.
- A polling read never waits, and returns a flag that says whether a result was there.

Reading Y consumes the result; reading X does not. A per-client restart input clears only the in-flight count. Stored results and operations already in the pipeline survive it.

Top module: `shmul_result_hub`

## Requirements
- R1: The issue slot is client 0 in the first cycle after reset and advances by one client each cycle, wrapping after the last. A client is granted (`req_gnt`) only in its own slot, so a client that holds its request is granted once every NCLI cycles whatever the others do.
- R2: A result arrives exactly LAT cycles after the cycle in which its request was granted.
- R3: A multiply of unsigned 32-bit operands returns the low half of the 64-bit product as X (`rd_sel_y`=0) and the high half as Y (`rd_sel_y`=1).
- R4: A newly arrived result replaces an unread one in the client's register; only the latest can be read.
- R5: A completed read of X with a valid result leaves the valid flag set. A completed read of Y with a valid result clears it.
- R6: A blocking read (`rd_poll`=0) with no valid result and a non-zero in-flight count holds `rd_stall`=1 and `rd_done`=0. It completes in the arrival cycle with the arriving word and the flag set.
- R7: A blocking read with no valid result and no operation in flight completes in the same cycle with data 0.
- R8: A polling read (`rd_poll`=1) completes in the cycle it is requested and never stalls. It returns the register word, with `rd_flag`=1 only if a valid result was present or arriving.
- R9: A client restart (`cli_rst`) clears that client's in-flight count only. The stored result is kept, and an operation already in the pipeline is still delivered and can be read.
- R10: No grant is given to a client while its restart input is high, and a client's in-flight count never exceeds LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cli_rst | input | NCLI | Per-client restart, clears that client's in-flight count |
| req_valid | input | NCLI | Per-client request pending |
| req_a | input | NCLI*W | Per-client first operand |
| req_b | input | NCLI*W | Per-client second operand |
| req_gnt | output | NCLI | Request taken this cycle |
| rd_en | input | NCLI | Per-client read request |
| rd_sel_y | input | NCLI | 0 reads X, 1 reads Y |
| rd_poll | input | NCLI | 1 polling read, 0 blocking read |
| rd_done | output | NCLI | Read completes this cycle |
| rd_stall | output | NCLI | Blocking read is waiting |
| rd_flag | output | NCLI | A valid result is present or arriving |
| rd_data | output | NCLI*W | Per-client read word |

## Verification
Two events can fall in the same cycle for one client: the arrival of a result and a consuming Y read. The bench provokes this by starting a blocking Y read in the cycle after the grant and holding it until it completes. That completion must land in the arrival cycle and return the arriving high word. A following poll must then see the flag clear, because the result was consumed in the same cycle it arrived. A restart that overlaps an operation still in the pipeline is judged the same way. The read made after the restart must not stall, and the result must still appear later.

// File: rtl/shmul_result_hub.sv
module shmul_result_hub #(
  parameter int NCLI = 4,
  parameter int LAT  = 6,
  parameter int W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLI-1:0]   cli_rst,
  input  logic [NCLI-1:0]   req_valid,
  input  logic [NCLI*W-1:0] req_a,
  input  logic [NCLI*W-1:0] req_b,
  output logic [NCLI-1:0]   req_gnt,
  input  logic [NCLI-1:0]   rd_en,
  input  logic [NCLI-1:0]   rd_sel_y,
  input  logic [NCLI-1:0]   rd_poll,
  output logic [NCLI-1:0]   rd_done,
  output logic [NCLI-1:0]   rd_stall,
  output logic [NCLI-1:0]   rd_flag,
  output logic [NCLI*W-1:0] rd_data
);
  localparam int IW = (NCLI > 1) ? $clog2(NCLI) : 1;
  localparam int CW = $clog2(LAT + 1);
  localparam int PW = 2 * W;

  logic [IW-1:0]           slot;
  logic [NCLI-1:0][CW-1:0] cnt;
  logic [NCLI-1:0]         vld;
  logic [NCLI-1:0][PW-1:0] res;
  logic [LAT-1:0]          pv;
  logic [LAT-1:0][IW-1:0]  pid;
  logic [LAT-1:0][PW-1:0]  pp;
  logic [NCLI-1:0]         arrive, consume;
  logic [W-1:0]            a_s, b_s;
  logic                    iss;

  assign a_s = req_a[int'(slot)*W +: W];
  assign b_s = req_b[int'(slot)*W +: W];
  assign iss = req_valid[slot] & ~cli_rst[slot] & (cnt[slot] != CW'(LAT));

  for (genvar i = 0; i < NCLI; i++) begin : g_cli
    logic          have, empty_blk;
    logic [PW-1:0] cur;
    logic [W-1:0]  word;
    assign req_gnt[i]  = iss && (slot == IW'(i));
    assign arrive[i]   = pv[LAT-1] && (pid[LAT-1] == IW'(i));
    assign have        = vld[i] | arrive[i];
    assign cur         = arrive[i] ? pp[LAT-1] : res[i];
    assign word        = rd_sel_y[i] ? cur[PW-1:W] : cur[W-1:0];
    assign empty_blk   = rd_en[i] & ~rd_poll[i] & ~have;
    assign rd_stall[i] = empty_blk & (cnt[i] != '0);
    assign rd_done[i]  = rd_en[i] & ~rd_stall[i];
    assign rd_flag[i]  = have;
    assign consume[i]  = rd_done[i] & rd_sel_y[i] & have;
    assign rd_data[i*W +: W] = empty_blk ? '0 : word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      pv   <= '0;
      pid  <= '0;
      pp   <= '0;
    end else begin
      slot <= (slot == IW'(NCLI-1)) ? '0 : slot + 1'b1;
      pv   <= {pv[LAT-2:0], iss};
      pid  <= {pid[LAT-2:0], slot};
      pp   <= {pp[LAT-2:0], {{W{1'b0}}, a_s} * {{W{1'b0}}, b_s}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      vld <= '0;
      res <= '0;
    end else begin
      for (int i = 0; i < NCLI; i++) begin
        if (arrive[i]) res[i] <= pp[LAT-1];
        vld[i] <= (vld[i] | arrive[i]) & ~consume[i];
        if (cli_rst[i])
          cnt[i] <= '0;
        else if (req_gnt[i] && !arrive[i])
          cnt[i] <= cnt[i] + 1'b1;
        else if (!req_gnt[i] && arrive[i] && cnt[i] != '0)
          cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/shmul_result_hub_chk.sv
module shmul_result_hub_chk #(
  parameter int NCLI = 4,
  parameter int LAT  = 6,
  parameter int W    = 32,
  parameter int CW   = $clog2(LAT + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCLI-1:0]         cli_rst,
  input logic [NCLI-1:0]         req_valid,
  input logic [NCLI-1:0]         req_gnt,
  input logic [NCLI-1:0]         rd_en,
  input logic [NCLI-1:0]         rd_poll,
  input logic [NCLI-1:0]         rd_done,
  input logic [NCLI-1:0]         rd_stall,
  input logic [NCLI-1:0]         rd_flag,
  input logic [NCLI-1:0][CW-1:0] cnt
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_gnt)); // R1
  AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) (req_gnt & ~(req_valid & ~cli_rst)) == '0); // R10
  AST_STALL_IS_BLOCKING: assert property (@(posedge clk) disable iff (!rst_n) (rd_stall & ~rd_en) == '0); // R6
  AST_POLL_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (rd_stall & rd_poll) == '0); // R8
  AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (rd_stall & rd_flag) == '0); // R6

  for (genvar i = 0; i < NCLI; i++) begin : g_c
    AST_GRANT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n) req_gnt[i] |=> !req_gnt[i]); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt[i] <= CW'(LAT)); // R10
    AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (rd_done[i] && !rd_poll[i] && !rd_flag[i]) |-> cnt[i] == '0); // R7
    AST_STALL_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n) rd_stall[i] |-> cnt[i] != '0); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cli_rst[i] |=> cnt[i] == '0); // R9
  end
endmodule

bind shmul_result_hub shmul_result_hub_chk #(.NCLI(NCLI), .LAT(LAT), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cli_rst(cli_rst), .req_valid(req_valid),
  .req_gnt(req_gnt), .rd_en(rd_en), .rd_poll(rd_poll), .rd_done(rd_done),
  .rd_stall(rd_stall), .rd_flag(rd_flag), .cnt(cnt)
);

// File: tb/shmul_result_hub_tb_top.sv
module shmul_result_hub_tb_top;
  localparam int NCLI = 4;
  localparam int LAT  = 6;
  localparam int W    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCLI-1:0]   cli_rst = '0, req_valid = '0, rd_en = '0, rd_sel_y = '0, rd_poll = '0;
  logic [NCLI*W-1:0] req_a = '0, req_b = '0;
  logic [NCLI-1:0]   req_gnt, rd_done, rd_stall, rd_flag;
  logic [NCLI*W-1:0] rd_data;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  shmul_result_hub #(.NCLI(NCLI), .LAT(LAT), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cli_rst(cli_rst), .req_valid(req_valid),
    .req_a(req_a), .req_b(req_b), .req_gnt(req_gnt), .rd_en(rd_en),
    .rd_sel_y(rd_sel_y), .rd_poll(rd_poll), .rd_done(rd_done),
    .rd_stall(rd_stall), .rd_flag(rd_flag), .rd_data(rd_data)
  );

  function automatic logic [63:0] mul(logic [31:0] a, logic [31:0] b);
    return {32'd0, a} * {32'd0, b};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Starts and ends at a negedge; g is the grant cycle.
  task automatic do_issue(int i, logic [31:0] a, logic [31:0] b, output int g);
    req_valid[i] = 1'b1;
    req_a[i*W +: W] = a;
    req_b[i*W +: W] = b;
    forever begin
      #1;
      if (req_gnt[i]) begin g = cyc; break; end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid[i] = 1'b0;
  endtask

  // Single-cycle read sampled mid-cycle; starts and ends at a negedge.
  task automatic do_read(int i, bit y, bit poll, output logic [31:0] d,
                         output bit fl, output bit st, output bit dn);
    rd_en[i] = 1'b1; rd_sel_y[i] = y; rd_poll[i] = poll;
    #1;
    d = rd_data[i*W +: W]; fl = rd_flag[i]; st = rd_stall[i]; dn = rd_done[i];
    @(negedge clk);
    rd_en[i] = 1'b0; rd_sel_y[i] = 1'b0; rd_poll[i] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; bit fl, st, dn;
    #1;
    chk("R1 no grant after reset", req_gnt, 0);
    @(negedge clk);
    do_read(0, 1'b1, 1'b0, d, fl, st, dn);
    chk("R7 empty blocking read done", dn, 1);
    chk("R7 empty blocking read no stall", st, 0);
    chk("R7 empty blocking read data", d, 0);
    do_read(0, 1'b1, 1'b1, d, fl, st, dn);
    chk("R8 poll flag with nothing", fl, 0);
  endtask

  task automatic t_latency;
    int g, k;
    logic [63:0] p;
    logic [31:0] d; bit fl, st, dn;
    p = mul(32'hFFFF_FFFF, 32'd2);
    do_issue(1, 32'hFFFF_FFFF, 32'd2, g);
    chk("R1 grant in own slot", g % NCLI, 1);
    rd_en[1] = 1'b1; rd_sel_y[1] = 1'b1; rd_poll[1] = 1'b0;
    #1;
    chk("R6 stall while in flight", rd_stall[1], 1);
    chk("R6 no done while stalled", rd_done[1], 0);
    for (k = 0; k < 4 * LAT; k++) begin
      if (rd_done[1]) break;
      @(negedge clk); #1;
    end
    chk("R2 completion in arrival cycle", cyc - g, LAT);
    chk("R3 Y is high half", rd_data[W +: W], p[63:32]);
    chk("R6 flag at arrival", rd_flag[1], 1);
    @(negedge clk);
    rd_en[1] = 1'b0; rd_sel_y[1] = 1'b0;
    do_read(1, 1'b0, 1'b1, d, fl, st, dn);
    chk("R5 Y read at arrival consumed", fl, 0);
    chk("R3 X is low half", d, p[31:0]);
  endtask

  task automatic t_xy;
    int g;
    logic [63:0] p;
    logic [31:0] d; bit fl, st, dn;
    p = mul(32'h1234_5678, 32'h9ABC_DEF0);
    do_issue(2, 32'h1234_5678, 32'h9ABC_DEF0, g);
    repeat (LAT + 1) @(negedge clk);
    do_read(2, 1'b0, 1'b0, d, fl, st, dn);
    chk("R3 blocking X data", d, p[31:0]);
    chk("R6 valid blocking read no stall", st, 0);
    do_read(2, 1'b0, 1'b1, d, fl, st, dn);
    chk("R5 X read keeps flag", fl, 1);
    do_read(2, 1'b1, 1'b0, d, fl, st, dn);
    chk("R3 blocking Y data", d, p[63:32]);
    do_read(2, 1'b1, 1'b1, d, fl, st, dn);
    chk("R5 Y read clears flag", fl, 0);
    chk("R8 poll returns register", d, p[63:32]);
  endtask

  task automatic t_overwrite;
    int g1, g2;
    logic [31:0] d; bit fl, st, dn;
    do_issue(3, 32'd3, 32'd5, g1);
    do_issue(3, 32'h8000_0007, 32'd11, g2);
    chk("R1 held request rate", g2 - g1, NCLI);
    repeat (LAT + 1) @(negedge clk);
    do_read(3, 1'b0, 1'b1, d, fl, st, dn);
    chk("R4 X holds latest result", d, mul(32'h8000_0007, 32'd11) & 64'hFFFF_FFFF);
    chk("R4 flag set", fl, 1);
    do_read(3, 1'b1, 1'b1, d, fl, st, dn);
    chk("R4 Y holds latest result", d, mul(32'h8000_0007, 32'd11) >> 32);
  endtask

  task automatic t_all;
    int gc[NCLI];
    logic [NCLI-1:0] got = '0;
    int first = -1;
    logic [31:0] d; bit fl, st, dn;
    for (int i = 0; i < NCLI; i++) begin
      req_a[i*W +: W] = 32'hF000_0000 + i;
      req_b[i*W +: W] = 32'h1000 + 7 * i;
      gc[i] = -1;
    end
    req_valid = '1;
    for (int k = 0; k < 2 * NCLI; k++) begin
      logic [NCLI-1:0] now;
      #1;
      now = req_gnt;
      chk("R1 at most one grant", $countones(now) <= 1, 1);
      for (int i = 0; i < NCLI; i++)
        if (now[i] && !got[i]) begin
          gc[i] = cyc;
          if (first < 0) first = cyc;
        end
      got = got | now;
      @(negedge clk);
      req_valid = req_valid & ~now;
    end
    req_valid = '0;
    for (int i = 0; i < NCLI; i++) begin
      chk($sformatf("R1 client %0d slot", i), gc[i] % NCLI, i);
      chk($sformatf("R1 client %0d within one round", i), (gc[i] - first) < NCLI, 1);
    end
    repeat (LAT) @(negedge clk);
    for (int i = 0; i < NCLI; i++) begin
      do_read(i, 1'b1, 1'b1, d, fl, st, dn);
      chk($sformatf("R3 client %0d Y", i), d, mul(32'hF000_0000 + i, 32'h1000 + 7 * i) >> 32);
      chk($sformatf("R8 client %0d flag", i), fl, 1);
    end
  endtask

  task automatic t_poll_flight;
    int g;
    logic [31:0] d; bit fl, st, dn;
    do_issue(0, 32'd9, 32'd9, g);
    do_read(0, 1'b0, 1'b1, d, fl, st, dn);
    chk("R8 poll in flight no stall", st, 0);
    chk("R8 poll in flight done", dn, 1);
    chk("R8 poll in flight flag", fl, 0);
    chk("R8 poll returns old register", d, mul(32'hF000_0000, 32'h1000) & 64'hFFFF_FFFF);
    repeat (LAT) @(negedge clk);
    do_read(0, 1'b0, 1'b1, d, fl, st, dn);
    chk("R8 poll after arrival", d, 81);
    chk("R8 poll flag after arrival", fl, 1);
  endtask

  task automatic t_restart;
    int g;
    logic [31:0] d; bit fl, st, dn;
    do_issue(1, 32'hDEAD_BEEF, 32'h100, g);
    cli_rst[1] = 1'b1;
    req_valid[1] = 1'b1;
    req_a[W +: W] = 32'd1;
    for (int k = 0; k < NCLI; k++) begin
      #1;
      chk("R10 no grant during restart", req_gnt[1], 0);
      @(negedge clk);
    end
    cli_rst[1] = 1'b0;
    req_valid[1] = 1'b0;
    chk("R9 still before arrival", cyc - g < LAT, 1);
    do_read(1, 1'b1, 1'b0, d, fl, st, dn);
    chk("R9 count cleared no stall", st, 0);
    chk("R9 count cleared read done", dn, 1);
    chk("R9 count cleared data zero", d, 0);
    repeat (2) @(negedge clk);
    do_read(1, 1'b1, 1'b1, d, fl, st, dn);
    chk("R9 pending result delivered", d, mul(32'hDEAD_BEEF, 32'h100) >> 32);
    chk("R9 pending result flag", fl, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_latency;
    t_xy;
    t_overwrite;
    t_all;
    t_poll_flight;
    t_restart;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule